// File: doc/BRIEF.md
# Single-Edge TCK Clock-Enable Synchronizer

This block lets a test access port that runs on its own, unrelated TCK sit inside a design where every flop is clocked by the rising edge of one system clock. TCK is never used as a clock. It is sampled through a short chain of flops. Each change of the synchronized level becomes a one-cycle enable pulse: one pulse for a rising TCK edge and another for a falling TCK edge. Downstream test logic (state machine, scan chains) runs on the system clock and advances only when these enables are set.

The block returns a TCK echo. This echo takes the new TCK level one system cycle after the matching enable pulse. A debugger that waits for the echo before it makes its next TCK transition can never drive TCK faster than the synchronizer can follow. No edge is lost, however slow or variable the system clock is. The serial output is loaded from the internal data only on the falling enable. The mode and data inputs are captured only on the rising enable. All port-side changes therefore line up with TCK edges.

Top module: `tck_enable_sync`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, both enables, `rtck_o`, `tdo_o`, `tms_q_o` and `tdi_q_o` are 0.
- R2: Each rising transition of `tck_i` gives exactly one cycle of `tck_rise_en_o`. It is seen in the cycle that follows the SYNC_STAGES-th clock edge after the change.
- R3: Each falling transition of `tck_i` gives exactly one cycle of `tck_fall_en_o`, with the same latency as R2.
- R4: The two enables are never high in the same cycle. They alternate strictly, and the first one after reset is the rising enable.
- R5: `rtck_o` changes only at the clock edge that ends an enable cycle. It takes the value 1 after a rising enable and 0 after a falling enable.
- R6: `tdo_o` loads `tdo_core_i` only at the edge that ends a falling-enable cycle. Changes of `tdo_core_i` at other times have no effect on `tdo_o`.
- R7: `tms_q_o` and `tdi_q_o` capture `tms_i` and `tdi_i` only at the edge that ends a rising-enable cycle. Changes at other times have no effect.
- R8: SYNC_STAGES must be at least 1. A value of 1 builds a single sampling flop, and larger values build a chain of that length.
- R9: When the echo paces TCK (each transition waits for `rtck_o` to match), the number of enable pulses equals the number of TCK transitions, and none is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all flops use its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tck_i | input | 1 | Test clock from the debugger, asynchronous |
| tms_i | input | 1 | Test mode select from the debugger |
| tdi_i | input | 1 | Serial test data in |
| tdo_core_i | input | 1 | Serial data that internal logic presents for output |
| tck_rise_en_o | output | 1 | One-cycle enable for a TCK rising edge |
| tck_fall_en_o | output | 1 | One-cycle enable for a TCK falling edge |
| rtck_o | output | 1 | Returned TCK echo for debugger pacing |
| tdo_o | output | 1 | Registered serial test data out |
| tms_q_o | output | 1 | Mode select captured on the rising enable |
| tdi_q_o | output | 1 | Data in captured on the rising enable |

## Verification
The bench builds the block with SYNC_STAGES set to 3. This uses the multi-flop generate branch and gives a latency that differs from the default of 2, so a delay that is fixed in the RTL instead of derived from the parameter is caught. The scoreboard checks every enable against the cycle its TCK transition was driven. Between transitions, the bench wiggles the data and mode inputs. This shows that only the matching enable cycle lets them into the registered outputs.

// File: rtl/tck_enable_sync_pkg.sv
package tck_enable_sync_pkg;

   // Captured debugger inputs, updated on the rising enable
   typedef struct packed {
      logic mode;
      logic data;
   } tap_in_t;

   // Kind of TCK transition last seen by the edge detector
   typedef enum logic {
      EDGE_FELL = 1'b0,
      EDGE_ROSE = 1'b1
   } edge_kind_t;

   localparam int unsigned MIN_SYNC_STAGES = 1;

endpackage

// File: rtl/tck_sync_chain.sv
module tck_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   import tck_enable_sync_pkg::*;

   initial begin
      if (STAGES < MIN_SYNC_STAGES)
         $error("tck_sync_chain: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= async_i;
         end
         assign sync_o = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[STAGES-2:0], async_i};
         end
         assign sync_o = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tck_edge_detect.sv
module tck_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_en_o,
   output logic fall_en_o,
   output logic level_q_o
);
   import tck_enable_sync_pkg::*;

   logic       level_q;
   edge_kind_t last_kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_i;
   end

   assign rise_en_o = level_i & ~level_q;
   assign fall_en_o = ~level_i & level_q;
   assign level_q_o = level_q;

   // Tracks the most recent enable; reset state matches TCK low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         last_kind <= EDGE_FELL;
      else if (rise_en_o) last_kind <= EDGE_ROSE;
      else if (fall_en_o) last_kind <= EDGE_FELL;
   end

   AST_RISE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_en_o |=> !rise_en_o); // R2
   AST_FALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_en_o |=> !fall_en_o); // R3
   AST_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      rise_en_o |-> (last_kind == EDGE_FELL)); // R4
   AST_FALL_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_en_o |-> (last_kind == EDGE_ROSE)); // R4

endmodule

// File: rtl/tck_port_regs.sv
module tck_port_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_en_i,
   input  logic fall_en_i,
   input  logic level_i,
   input  logic tms_i,
   input  logic tdi_i,
   input  logic tdo_core_i,
   output logic rtck_o,
   output logic tdo_o,
   output logic tms_q_o,
   output logic tdi_q_o
);
   import tck_enable_sync_pkg::*;

   tap_in_t cap_q;
   logic    echo_q;
   logic    tdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       echo_q <= 1'b0;
      else if (rise_en_i || fall_en_i)  echo_q <= level_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tdo_q <= 1'b0;
      else if (fall_en_i) tdo_q <= tdo_core_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cap_q <= '0;
      else if (rise_en_i) cap_q <= '{mode: tms_i, data: tdi_i};
   end

   assign rtck_o  = echo_q;
   assign tdo_o   = tdo_q;
   assign tms_q_o = cap_q.mode;
   assign tdi_q_o = cap_q.data;

   AST_RTCK_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (echo_q != $past(echo_q)) |-> $past(rise_en_i || fall_en_i)); // R5
   AST_RTCK_HIGH_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_en_i |=> echo_q); // R5
   AST_RTCK_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      fall_en_i |=> !echo_q); // R5
   AST_TDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_en_i |=> $stable(tdo_q)); // R6
   AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_en_i |=> $stable(cap_q)); // R7

endmodule

// File: rtl/tck_enable_sync.sv
module tck_enable_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tck_i,
   input  logic tms_i,
   input  logic tdi_i,
   input  logic tdo_core_i,
   output logic tck_rise_en_o,
   output logic tck_fall_en_o,
   output logic rtck_o,
   output logic tdo_o,
   output logic tms_q_o,
   output logic tdi_q_o
);
   import tck_enable_sync_pkg::*;

   initial begin
      if (SYNC_STAGES < MIN_SYNC_STAGES)
         $error("tck_enable_sync: SYNC_STAGES below minimum"); // R8
   end

   logic tck_sync;
   logic tck_prev;
   logic rise_en;
   logic fall_en;

   tck_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (tck_i),
      .sync_o  (tck_sync)
   );

   tck_edge_detect u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (tck_sync),
      .rise_en_o (rise_en),
      .fall_en_o (fall_en),
      .level_q_o (tck_prev)
   );

   tck_port_regs u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_en_i  (rise_en),
      .fall_en_i  (fall_en),
      .level_i    (tck_sync),
      .tms_i      (tms_i),
      .tdi_i      (tdi_i),
      .tdo_core_i (tdo_core_i),
      .rtck_o     (rtck_o),
      .tdo_o      (tdo_o),
      .tms_q_o    (tms_q_o),
      .tdi_q_o    (tdi_q_o)
   );

   assign tck_rise_en_o = rise_en;
   assign tck_fall_en_o = fall_en;

   AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_en && fall_en)); // R4
   AST_ECHO_MATCHES_PREV: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_en || fall_en) |=> (rtck_o == tck_prev)); // R5

endmodule

// File: tb/tck_enable_sync_tb.sv
module tck_enable_sync_tb;

   localparam int unsigned SYNC = 3;

   typedef struct {
      bit rise;
      bit tms;
      bit tdi;
      bit tdo;
      int t;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tck = 1'b0, tms = 1'b0, tdi = 1'b0, tdo_core = 1'b0;
   logic rise_en, fall_en, rtck, tdo, tms_q, tdi_q;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int drives = 0;
   int enables = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;
   item_t exp_q[$];

   always #2 clk = ~clk; // 250 MHz

   always @(posedge clk) cyc <= cyc + 1;

   tck_enable_sync #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .tck_i(tck), .tms_i(tms), .tdi_i(tdi),
      .tdo_core_i(tdo_core), .tck_rise_en_o(rise_en), .tck_fall_en_o(fall_en),
      .rtck_o(rtck), .tdo_o(tdo), .tms_q_o(tms_q), .tdi_q_o(tdi_q)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Driver: one TCK transition, paced by the returned echo (R9)
   task automatic drive_edge(input bit lvl, input bit ms, input bit di, input bit dout);
      item_t it;
      @(negedge clk);
      tck = lvl; tms = ms; tdi = di; tdo_core = dout;
      it.rise = lvl; it.tms = ms; it.tdi = di; it.tdo = dout; it.t = cyc;
      exp_q.push_back(it);
      drives++;
      while (rtck !== lvl) @(negedge clk);
      // Disturb inputs outside the enable window: must have no effect (R6, R7)
      repeat (2) begin
         @(negedge clk);
         tms = $urandom_range(1); tdi = $urandom_range(1); tdo_core = $urandom_range(1);
      end
   endtask

   // Monitor / scoreboard
   initial begin : monitor
      bit    pend = 1'b0;
      item_t cur;
      logic  s_rtck, s_tdo, s_tms, s_tdi;
      bit    prev_en = 1'b0;
      wait (mon_on);
      s_rtck = rtck; s_tdo = tdo; s_tms = tms_q; s_tdi = tdi_q;
      forever begin
         @(negedge clk);
         if (done) break;
         if (pend) begin
            check(rtck == cur.rise, "R5 rtck after enable", rtck, cur.rise);
            if (cur.rise) begin
               check(tms_q == cur.tms, "R7 tms capture", tms_q, cur.tms);
               check(tdi_q == cur.tdi, "R7 tdi capture", tdi_q, cur.tdi);
               check(tdo == s_tdo, "R6 tdo held on rise", tdo, s_tdo);
            end else begin
               check(tdo == cur.tdo, "R6 tdo load on fall", tdo, cur.tdo);
               check(tms_q == s_tms && tdi_q == s_tdi, "R7 capture held on fall",
                     {tms_q, tdi_q}, {s_tms, s_tdi});
            end
            pend = 1'b0;
         end else if (!prev_en) begin
            check(rtck == s_rtck, "R5 rtck stable", rtck, s_rtck);
            check(tdo == s_tdo, "R6 tdo stable", tdo, s_tdo);
            check(tms_q == s_tms && tdi_q == s_tdi, "R7 capture stable",
                  {tms_q, tdi_q}, {s_tms, s_tdi});
         end
         check(!(rise_en && fall_en), "R4 exclusive enables", rise_en + fall_en, 1);
         if (rise_en || fall_en) begin
            check(!prev_en, "R2 R3 single cycle enable", prev_en, 0);
            enables++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected enable", enables, drives);
            end else begin
               cur = exp_q.pop_front();
               check(rise_en == cur.rise, cur.rise ? "R2 rise kind" : "R3 fall kind",
                     rise_en, cur.rise);
               check(cyc - cur.t == SYNC, cur.rise ? "R2 latency" : "R3 latency",
                     cyc - cur.t, SYNC);
               pend = 1'b1;
            end
         end
         prev_en = rise_en || fall_en;
         s_rtck = rtck; s_tdo = tdo; s_tms = tms_q; s_tdi = tdi_q;
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // Reset with noisy inputs (R1)
      tms = 1'b1; tdi = 1'b1; tdo_core = 1'b1;
      repeat (4) @(negedge clk);
      check({rise_en, fall_en, rtck, tdo, tms_q, tdi_q} == 6'b0, "R1 reset state",
            {rise_en, fall_en, rtck, tdo, tms_q, tdi_q}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({rise_en, fall_en, rtck, tdo, tms_q, tdi_q} == 6'b0, "R1 after release",
            {rise_en, fall_en, rtck, tdo, tms_q, tdi_q}, 0);
      mon_on = 1'b1;
      // Fixed patterns: ones, zeros, alternating (R2 R3 R6 R7)
      drive_edge(1'b1, 1'b1, 1'b1, 1'b0);
      drive_edge(1'b0, 1'b0, 1'b0, 1'b1);
      drive_edge(1'b1, 1'b0, 1'b1, 1'b1);
      drive_edge(1'b0, 1'b1, 1'b0, 1'b0);
      // Random burst of paced transitions (R9)
      for (int i = 0; i < 60; i++) begin
         drive_edge(~tck, $urandom_range(1), $urandom_range(1), $urandom_range(1));
      end
      repeat (10) @(negedge clk);
      check(enables == drives, "R9 enable count", enables, drives);
      check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
      done = 1'b1;
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule